// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs the two-wire station management link between a MAC and an external PHY. Software loads one 32-bit management word that holds start code, operation, PHY address, register address, turnaround code and data. The engine then sends a complete frame on MDC/MDIO. While the frame is in flight an idle flag is low. On a read the engine stops driving MDIO from the turnaround onward. It shifts the sixteen bits returned by the PHY into the low half of the same word, where software collects them once idle rises again.

A management-port enable gates everything. Commands are taken only while it is high. If it is dropped in the middle of a frame, the divider and bit counter freeze and the line holds its level until the enable returns. MDC is the system clock divided by a fixed ratio.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and cmd_word is all zeros.
- R2: When cmd_wr is high with port_en high and idle high, cmd_wdata is loaded into cmd_word at that clock edge and idle reads 0 from the next cycle on.
- R3: One MDC period lasts CLK_DIV (32) system clocks. MDC is low for the first half of each bit period and high for the second half, and it stays low while idle.
- R4: Each frame opens with PRE_LEN (32) bit periods in which MDIO is driven to 1.
- R5: After the preamble, cmd_word bits 31 down to 0 are sent one per bit period, most significant first. Bits 31:30 are the start code (01), bits 29:28 the operation, bits 27:23 the PHY address, bits 22:18 the register address, bits 17:16 the turnaround and bits 15:0 the data. Each bit is valid throughout its MDC low half.
- R6: When bits 29:28 equal 10 (read), mdio_oe is 0 from frame bit 14 (word bit 17) to the end of the frame. mdio_i is sampled at each MDC rising edge of the last 16 bit periods and stored in cmd_word[15:0], first sample in bit 15. Bits 31:16 keep their value.
- R7: idle returns to 1 exactly (PRE_LEN+32)*CLK_DIV = 2048 clocks after the accepting edge, and not before.
- R8: A cmd_wr while idle is 0 leaves cmd_word unchanged and neither restarts nor stretches the running frame.
- R9: A cmd_wr while port_en is 0 is ignored. Dropping port_en mid-frame freezes mdc, mdio_o and mdio_oe, and raising it again resumes the frame, which is delayed by the number of paused clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Management port enable |
| cmd_wr | input | 1 | Write strobe for the management word |
| cmd_wdata | input | 32 | Management word to load |
| cmd_word | output | 32 | Current management word, read data in bits 15:0 |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Data input from the MDIO pad |
| mdio_o | output | 1 | Data output to the MDIO pad |
| mdio_oe | output | 1 | Output enable of the MDIO pad (0 = released) |

## Verification
The assertions check several rules on every cycle. An accepted command always drops idle. Upper word bits never move without a load. MDC rises only out of the divider's mid-count. MDC holds while the port is disabled. The line is released only during a read. Busy ends only on the last bit. Only the bench's scenarios can show the rest, because each needs a known command and PHY reply. These are the bit-exact preamble and frame contents, the placement of captured read data, the 2048-clock frame length, the ignored busy write and the exact delay a pause adds.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned MGMT_W = 32;
  localparam int unsigned DATA_W = 16;
  localparam logic [1:0]  OP_READ  = 2'b10;
  localparam logic [1:0]  OP_WRITE = 2'b01;
  // frame bit positions (0 = first bit after preamble)
  localparam logic [4:0]  REL_POS  = 5'd14;
  localparam logic [4:0]  DATA_POS = 5'd16;

  typedef struct packed {
    logic [1:0]        sof;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [1:0]        ta;
    logic [DATA_W-1:0] data;
  } mgmt_word_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned CLK_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic mdc,
  output logic rise_tick,
  output logic last_tick
);
  localparam int unsigned CNT_W = $clog2(CLK_DIV);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign rise_tick = run && (cnt_q == HALF_M1);
  assign last_tick = run && (cnt_q == LAST_V);
  assign mdc       = (cnt_q >= HALF_V);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run)
      cnt_d = last_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: mdc only rises out of the mid-count tick
  a_r3_rise_from_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_tick));
  // R9: a stalled divider keeps mdc level
  a_r9_stall_holds_mdc: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             last_tick,
  output logic             busy,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int unsigned TOTAL = PRE_LEN + mdio_pkg::MGMT_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic             busy_d;
  logic [IDX_W-1:0] idx_d;
  logic             at_end;

  assign at_end = last_tick && (bit_idx == LAST_IDX);

  always_comb begin
    busy_d = busy;
    idx_d  = bit_idx;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (last_tick) begin
      if (at_end) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = bit_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else begin
      busy    <= busy_d;
      bit_idx <= idx_d;
    end
  end

  // R7: busy ends only after the last bit period
  a_r7_end_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bit_idx) == LAST_IDX));
  // R2: a start always makes the engine busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/mdio_word_reg.sv
module mdio_word_reg
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MGMT_W-1:0] load_val,
  input  logic              busy,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              rise_tick,
  input  logic              mdio_i,
  output logic [MGMT_W-1:0] word,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [IDX_W-1:0] PRE_V = IDX_W'(PRE_LEN);

  mgmt_word_t  word_q, word_d;
  logic [MGMT_W-1:0] word_bits;
  logic        is_read, in_frame, released, capture;
  logic [4:0]  fpos, msb_pos;

  assign word_bits = word_q;
  assign word      = word_bits;
  assign is_read   = (word_q.op == OP_READ);
  assign in_frame  = (bit_idx >= PRE_V);
  assign fpos      = 5'(bit_idx - PRE_V);
  assign msb_pos   = 5'd31 - fpos;
  assign released  = busy && in_frame && is_read && (fpos >= REL_POS);
  assign capture   = rise_tick && in_frame && is_read && (fpos >= DATA_POS);

  assign mdio_oe = busy && !released;
  assign mdio_o  = (!busy || !in_frame) ? 1'b1 : word_bits[msb_pos];

  always_comb begin
    word_d = word_q;
    if (load)
      word_d = load_val;
    else if (capture)
      word_d.data = {word_q.data[DATA_W-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // R8/R6: header half of the word changes only on an accepted load
  a_r8_header_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_bits[MGMT_W-1:DATA_W]));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int unsigned CLK_DIV = 32,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_word,
  output logic        idle,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int unsigned TOTAL = PRE_LEN + mdio_pkg::MGMT_W;
  localparam int unsigned IDX_W = $clog2(TOTAL);

  logic             busy, start, run, clr, rise_tick, last_tick;
  logic [IDX_W-1:0] bit_idx;

  assign start = cmd_wr && port_en && !busy;
  assign run   = busy && port_en;
  assign clr   = !busy;
  assign idle  = !busy;

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr),
    .mdc(mdc), .rise_tick(rise_tick), .last_tick(last_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .last_tick(last_tick),
    .busy(busy), .bit_idx(bit_idx)
  );

  mdio_word_reg #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_word (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(cmd_wdata),
    .busy(busy), .bit_idx(bit_idx), .rise_tick(rise_tick), .mdio_i(mdio_i),
    .word(cmd_word), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R2: accepted command clears idle next cycle
  a_r2_accept_drops_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && port_en && idle) |=> !idle);
  // R9: disabled port ignores commands
  a_r9_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && idle) |=> idle);
  // R9: pause freezes the line
  a_r9_pause_freezes_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !idle) |=> ($stable(mdc) && $stable(mdio_o) && $stable(mdio_oe)));
  // R6: the line is released only during a read frame
  a_r6_release_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !mdio_oe) |-> (cmd_word[29:28] == 2'b10));
  // R3: clock is low while idle
  a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdc);
endmodule

// File: tb/mdio_mgmt_engine_bench.sv
module mdio_mgmt_engine_bench;
  logic        clk, rst_n, port_en, cmd_wr, mdio_i;
  logic [31:0] cmd_wdata, cmd_word;
  logic        idle, mdc, mdio_o, mdio_oe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {management word, PHY reply data}
  localparam logic [47:0] VEC [4] = '{
    48'h5082_1200_0000,
    48'h6F86_FFFF_796D,
    48'h62FE_0000_8001,
    48'h5AAA_A5C3_0000
  };

  mdio_mgmt_engine u_mdio_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .cmd_word(cmd_word), .idle(idle), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [15:0] pd);
    logic rd;
    logic [31:0] expw;
    rd = (w[29:28] == 2'b10);
    issue(w);
    chk("R2 idle low after accept", 32'(idle), 32'd0);
    chk("R2 word loaded", cmd_word, w);
    for (int k = 0; k < 64; k++) begin
      int f;
      f = k - 32;
      repeat (4) @(negedge clk);
      chk("R3 mdc low half", 32'(mdc), 32'd0);
      if (k < 32) begin
        chk("R4 preamble driven", 32'(mdio_oe), 32'd1);
        chk("R4 preamble one", 32'(mdio_o), 32'd1);
        mdio_i = 1'b1;
      end else begin
        if (rd && f >= 14) begin
          chk("R6 line released", 32'(mdio_oe), 32'd0);
        end else begin
          chk("R5 line driven", 32'(mdio_oe), 32'd1);
          chk("R5 frame bit", 32'(mdio_o), 32'(w[31-f]));
        end
        mdio_i = (rd && f >= 16) ? pd[31-f] : 1'b1;
      end
      repeat (16) @(negedge clk);
      chk("R3 mdc high half", 32'(mdc), 32'd1);
      if (k == 63) begin
        repeat (11) @(negedge clk);
        chk("R7 still busy at 2047", 32'(idle), 32'd0);
        @(negedge clk);
        chk("R7 idle at 2048", 32'(idle), 32'd1);
      end else begin
        repeat (12) @(negedge clk);
      end
    end
    expw = rd ? {w[31:16], pd} : w;
    chk("R6 final word", cmd_word, expw);
    chk("R3 mdc low when idle", 32'(mdc), 32'd0);
    mdio_i = 1'b1;
  endtask

  initial begin
    logic [31:0] prev;
    logic m0, o0, e0;
    rst_n = 1'b0; port_en = 1'b1; cmd_wr = 1'b0; cmd_wdata = '0; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset idle", 32'(idle), 32'd1);
    chk("R1 reset mdc", 32'(mdc), 32'd0);
    chk("R1 reset oe", 32'(mdio_oe), 32'd0);
    chk("R1 reset word", cmd_word, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", 32'(idle), 32'd1);

    for (int i = 0; i < 4; i++) begin
      run_frame(VEC[i][47:16], VEC[i][15:0]);
      repeat (3) @(negedge clk);
    end

    // R9: write with port disabled is ignored
    prev = cmd_word;
    port_en = 1'b0;
    issue(32'h6000_0000);
    repeat (5) @(negedge clk);
    chk("R9 disabled write stays idle", 32'(idle), 32'd1);
    chk("R9 disabled write word kept", cmd_word, prev);
    chk("R9 disabled mdc low", 32'(mdc), 32'd0);
    port_en = 1'b1;
    repeat (2) @(negedge clk);

    // R8: write while busy is ignored, frame length unchanged
    issue(32'h5AAA_A5C3);
    repeat (100) @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = 32'h6F86_0000;
    @(negedge clk); cmd_wr = 1'b0;
    chk("R8 busy write word kept", cmd_word, 32'h5AAA_A5C3);
    repeat (1946) @(negedge clk);
    chk("R8 frame not restarted busy", 32'(idle), 32'd0);
    @(negedge clk);
    chk("R8 frame ends on time", 32'(idle), 32'd1);
    chk("R8 word after frame", cmd_word, 32'h5AAA_A5C3);
    repeat (3) @(negedge clk);

    // R9: pause mid-frame
    issue(32'h5082_1200);
    repeat (40) @(negedge clk);
    port_en = 1'b0;
    m0 = mdc; o0 = mdio_o; e0 = mdio_oe;
    repeat (50) @(negedge clk);
    chk("R9 pause mdc frozen", 32'(mdc), 32'(m0));
    chk("R9 pause mdio frozen", 32'(mdio_o), 32'(o0));
    chk("R9 pause oe frozen", 32'(mdio_oe), 32'(e0));
    chk("R9 pause still busy", 32'(idle), 32'd0);
    port_en = 1'b1;
    repeat (2007) @(negedge clk);
    chk("R9 resumed frame busy", 32'(idle), 32'd0);
    @(negedge clk);
    chk("R9 resumed frame ends", 32'(idle), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (R7 completion) actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule